// File: doc/BRIEF.md
# Dual 32-bit or 64-bit Timer

A memory-mapped count-up timer that software runs either as one wide general-purpose counter or as two independent counters, the lower and upper halves. Each half has a counter, a period register and a 2-bit enable mode (disabled, one-shot, periodic). Each half also has its own one-cycle interrupt pulse, raised when its count reaches its period. A global control register selects how the halves are used and holds a release bit for each half. A half stays cleared at zero until software sets its release bit.

Software configures the block through a simple register bus. Writes take effect at the clock edge where `bus_sel` and `bus_wr` are both high. Reads are combinational: `bus_rdata` always shows the register that `bus_addr` selects. The width of each half is the parameter `HALF_W` (32 by default), so the wide mode counts over `2*HALF_W` bits.

Top module: `dual_timer`

## Requirements
- R1: After reset every register reads zero, both release bits are 0, both enable fields are disabled and both interrupt outputs are low.
- R2: Byte addresses are 0x10 lower counter, 0x14 upper counter, 0x18 lower period, 0x1C upper period, 0x20 timer control and 0x24 global control. Period registers read back what was written. Timer control keeps only its two enable fields: the lower field is at bits [7:6] and the upper field at bits [23:22]. Global control keeps bits [3:0]. Unmapped addresses read zero.
- R3: The enable encoding is 0 disabled, 1 one-shot, 2 periodic, with 3 treated as disabled. A half counts up by one per clock only while its release bit is 1 and its enable field is 1 or 2.
- R4: With its enable field at 0 or 3, a released half holds its count unchanged.
- R5: Global control bit 0 releases the lower half and bit 1 releases the upper half. While a half's bit is 0, its counter reads zero and writes to that counter are ignored.
- R6: In periodic mode a counting half that holds a count equal to its period drives its interrupt high for exactly the next cycle and restarts from zero. Pulses are therefore P+1 cycles apart for period P.
- R7: In one-shot mode the match gives one interrupt pulse. The counter then stays at the period value and the enable field reads back 0.
- R8: In dual mode (mode field, bits [3:2], equal to 1) the halves are independent. Each has its own period, enable field and interrupt: `irq_lo` for the lower half and `irq_hi` for the upper half.
- R9: With mode 0 or 2, the lower and upper counters form one counter: lower is the low word, carrying into upper. It is compared against {upper period, lower period}. It is controlled by the lower enable field and needs both release bits. Its match drives `irq_lo`; `irq_hi` stays low and the upper enable field has no effect.
- R10: Mode 3 behaves exactly as mode 1.
- R11: A bus write to a released counter loads the written value at that edge, taking priority over counting and reload.
- R12: A periodic half with an all-ones period wraps through its full range: after reaching all ones it pulses its interrupt and continues from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high (with bus_sel) |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq_lo | output | 1 | Lower half (or wide counter) match pulse |
| irq_hi | output | 1 | Upper half match pulse |

## Verification
The bench builds the block with `HALF_W` set to 8, so a half wraps after 256 counts and the wide counter spans only 16 bits. This makes full-range wraps, the carry from the low word into the high word and wide-counter matches reachable within a few hundred cycles. Periodic and one-shot periods are swept across a range of small values on both halves at once. Every pulse position is predicted from the period arithmetic, and the wide mode is exercised under both of its mode codes.

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int HALF_W = 32,
  parameter int AW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq_lo,
  output logic          irq_hi
);
  localparam logic [AW-1:0] A_CNT_LO = AW'(8'h10);
  localparam logic [AW-1:0] A_CNT_HI = AW'(8'h14);
  localparam logic [AW-1:0] A_PRD_LO = AW'(8'h18);
  localparam logic [AW-1:0] A_PRD_HI = AW'(8'h1C);
  localparam logic [AW-1:0] A_TCTL   = AW'(8'h20);
  localparam logic [AW-1:0] A_GCTL   = AW'(8'h24);
  localparam int EN_LO_POS = 6;
  localparam int EN_HI_POS = 22;
  localparam logic [1:0] EN_OFF = 2'd0, EN_ONE = 2'd1, EN_PER = 2'd2;

  logic [HALF_W-1:0] cnt_lo, cnt_hi, prd_lo, prd_hi;
  logic [HALF_W-1:0] nxt_lo, nxt_hi;
  logic [1:0]        en_lo, en_hi, mode;
  logic              rs_lo, rs_hi;
  logic              irq_lo_q, irq_hi_q;

  wire wr       = bus_sel & bus_wr;
  wire wr_cnt_lo = wr & (bus_addr == A_CNT_LO);
  wire wr_cnt_hi = wr & (bus_addr == A_CNT_HI);
  wire wr_prd_lo = wr & (bus_addr == A_PRD_LO);
  wire wr_prd_hi = wr & (bus_addr == A_PRD_HI);
  wire wr_tcr    = wr & (bus_addr == A_TCTL);
  wire wr_gctl   = wr & (bus_addr == A_GCTL);

  wire dual   = mode[0];
  wire act_lo = (en_lo == EN_ONE) | (en_lo == EN_PER);
  wire act_hi = (en_hi == EN_ONE) | (en_hi == EN_PER);
  wire run_lo = rs_lo & act_lo & (dual | rs_hi);
  wire run_hi = dual & rs_hi & act_hi;
  wire hit_lo = run_lo & (dual ? (cnt_lo == prd_lo)
                               : ({cnt_hi, cnt_lo} == {prd_hi, prd_lo}));
  wire hit_hi = run_hi & (cnt_hi == prd_hi);
  wire carry  = !dual & run_lo & !hit_lo & !wr_cnt_lo & (&cnt_lo);

  wire unused_wdata = ^bus_wdata;

  always_comb begin
    nxt_lo = cnt_lo;
    if (!rs_lo)         nxt_lo = '0;
    else if (wr_cnt_lo) nxt_lo = bus_wdata[HALF_W-1:0];
    else if (hit_lo)    nxt_lo = (en_lo == EN_PER) ? '0 : cnt_lo;
    else if (run_lo)    nxt_lo = cnt_lo + 1'b1;

    nxt_hi = cnt_hi;
    if (!rs_hi)         nxt_hi = '0;
    else if (wr_cnt_hi) nxt_hi = bus_wdata[HALF_W-1:0];
    else if (dual) begin
      if (hit_hi)       nxt_hi = (en_hi == EN_PER) ? '0 : cnt_hi;
      else if (run_hi)  nxt_hi = cnt_hi + 1'b1;
    end else begin
      if (hit_lo)       nxt_hi = (en_lo == EN_PER) ? '0 : cnt_hi;
      else if (carry)   nxt_hi = cnt_hi + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0; cnt_hi <= '0; prd_lo <= '0; prd_hi <= '0;
      en_lo <= EN_OFF; en_hi <= EN_OFF; mode <= '0;
      rs_lo <= 1'b0; rs_hi <= 1'b0;
      irq_lo_q <= 1'b0; irq_hi_q <= 1'b0;
    end else begin
      irq_lo_q <= hit_lo;
      irq_hi_q <= hit_hi;
      cnt_lo   <= nxt_lo;
      cnt_hi   <= nxt_hi;
      if (wr_prd_lo) prd_lo <= bus_wdata[HALF_W-1:0];
      if (wr_prd_hi) prd_hi <= bus_wdata[HALF_W-1:0];
      if (wr_gctl) begin
        rs_lo <= bus_wdata[0];
        rs_hi <= bus_wdata[1];
        mode  <= bus_wdata[3:2];
      end
      if (wr_tcr) begin
        en_lo <= bus_wdata[EN_LO_POS +: 2];
        en_hi <= bus_wdata[EN_HI_POS +: 2];
      end else begin
        if (hit_lo && en_lo == EN_ONE) en_lo <= EN_OFF;
        if (hit_hi && en_hi == EN_ONE) en_hi <= EN_OFF;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT_LO: bus_rdata = 32'(cnt_lo);
      A_CNT_HI: bus_rdata = 32'(cnt_hi);
      A_PRD_LO: bus_rdata = 32'(prd_lo);
      A_PRD_HI: bus_rdata = 32'(prd_hi);
      A_TCTL: begin
        bus_rdata[EN_LO_POS +: 2] = en_lo;
        bus_rdata[EN_HI_POS +: 2] = en_hi;
      end
      A_GCTL:   bus_rdata[3:0] = {mode, rs_hi, rs_lo};
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_lo = irq_lo_q;
  assign irq_hi = irq_hi_q;
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk #(
  parameter int HALF_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dual,
  input logic              rs_lo,
  input logic [1:0]        en_lo,
  input logic [HALF_W-1:0] cnt_lo,
  input logic              run_lo,
  input logic              hit_lo,
  input logic              wr_cnt_lo,
  input logic              wr_tcr,
  input logic              irq_hi
);
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dual && rs_lo && run_lo && !hit_lo && !wr_cnt_lo)
      |-> cnt_lo == HALF_W'($past(cnt_lo) + 1'b1));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dual && rs_lo && !wr_cnt_lo && (en_lo == 2'd0 || en_lo == 2'd3))
      |-> cnt_lo == $past(cnt_lo));

  // R5
  held_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rs_lo) |-> cnt_lo == '0);

  // R6
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dual && rs_lo && hit_lo && en_lo == 2'd2 && !wr_cnt_lo) |-> cnt_lo == '0);

  // R7
  oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit_lo && en_lo == 2'd1 && !wr_tcr) |-> en_lo == 2'd0);

  // R9
  wide_no_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!dual) |-> !irq_hi);
endmodule

bind dual_timer dual_timer_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dual(dual), .rs_lo(rs_lo), .en_lo(en_lo),
  .cnt_lo(cnt_lo), .run_lo(run_lo), .hit_lo(hit_lo),
  .wr_cnt_lo(wr_cnt_lo), .wr_tcr(wr_tcr), .irq_hi(irq_hi)
);

// File: tb/dual_timer_test.sv
`timescale 1ns/1ps
module dual_timer_test;
  localparam int HW = 8;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq_lo, irq_hi;
  int nchk = 0, nfail = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_timer #(.HALF_W(HW), .AW(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lo(irq_lo), .irq_hi(irq_hi));

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.1 d = bus_rdata;
  endtask

  task automatic stop_all();
    wr(8'h20, 0);
    wr(8'h10, 0);
    wr(8'h14, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, a, b;
    int first_lo, first_hi, cnt_lo_p, cnt_hi_p, gap_bad, last;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      rd(8'h10 + 8'(4*i), d);
      chk("R1 reg", d, 0);
    end
    chk("R1 irq_lo", irq_lo, 0);
    chk("R1 irq_hi", irq_hi, 0);

    // R2 readback and masking
    wr(8'h18, 32'hA5); rd(8'h18, d); chk("R2 prd_lo", d, 32'hA5);
    wr(8'h1C, 32'h3C); rd(8'h1C, d); chk("R2 prd_hi", d, 32'h3C);
    wr(8'h20, 32'hFFFFFFFF); rd(8'h20, d); chk("R2 tctl mask", d, 32'h00C000C0);
    wr(8'h24, 32'hFFFFFFFF); rd(8'h24, d); chk("R2 gctl mask", d, 32'hF);
    rd(8'h30, d); chk("R2 unmapped", d, 0);
    wr(8'h10, 32'h55); rd(8'h10, d); chk("R2 cnt_lo write", d, 32'h55);
    // R4 enable 3 holds
    rd(8'h10, a); repeat (4) @(negedge clk); rd(8'h10, b);
    chk("R4 enable 3 holds", b, a);

    // R5 release bits
    wr(8'h20, 32'h0); wr(8'h24, 32'h4);
    rd(8'h10, d); chk("R5 held zero", d, 0);
    wr(8'h10, 32'h22); rd(8'h10, d); chk("R5 write ignored", d, 0);
    wr(8'h20, 32'h00800080); repeat (3) @(negedge clk);
    rd(8'h14, d); chk("R5 held hi no count", d, 0);

    // R3 counting, R8 upper independent
    wr(8'h20, 0); wr(8'h24, 32'h7);
    wr(8'h18, 32'hFF); wr(8'h10, 0); wr(8'h14, 0);
    wr(8'h20, 32'h80);
    rd(8'h10, a); repeat (5) @(negedge clk); rd(8'h10, b);
    chk("R3 count rate", b - a, 6);
    rd(8'h14, d); chk("R8 upper idle", d, 0);
    // R4 disable freezes without clearing
    wr(8'h20, 0);
    rd(8'h10, a); repeat (5) @(negedge clk); rd(8'h10, b);
    chk("R4 freeze", b, a);
    chk("R4 not cleared", (a != 0), 1);

    // R11 write overrides counting
    wr(8'h20, 32'h80);
    wr(8'h10, 32'h80);
    #0.1 bus_addr = 8'h10; #0.1;
    chk("R11 loaded", bus_rdata, 32'h80);
    @(negedge clk); #0.1;
    chk("R11 continues", bus_rdata, 32'h81);

    // R12 full wrap
    wr(8'h20, 0); wr(8'h18, 32'hFF); wr(8'h10, 32'hFD);
    wr(8'h20, 32'h80);
    bus_addr = 8'h10;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk); #0.1;
      if (i == 2) chk("R12 at top", bus_rdata, 32'hFF);
      if (i == 3) begin chk("R12 irq", irq_lo, 1); chk("R12 wrapped", bus_rdata, 0); end
      if (i == 4) chk("R12 after", bus_rdata, 1);
    end

    // R6/R8 periodic sweep on both halves, dual (mode 1) and R10 (mode 3)
    for (int m = 0; m < 2; m++) begin
      for (int p = 1; p <= 10; p++) begin
        int q = p + 3;
        stop_all();
        wr(8'h24, m ? 32'hF : 32'h7);
        wr(8'h18, p); wr(8'h1C, q);
        wr(8'h20, 32'h00800080);
        first_lo = -1; first_hi = -1; cnt_lo_p = 0; cnt_hi_p = 0; gap_bad = 0; last = -1;
        for (int i = 1; i <= 4 * (q + 1); i++) begin
          @(negedge clk);
          if (irq_lo) begin
            if (first_lo < 0) first_lo = i;
            if (last >= 0 && i - last != p + 1) gap_bad++;
            last = i; cnt_lo_p++;
          end
          if (irq_hi) begin
            if (first_hi < 0) first_hi = i;
            cnt_hi_p++;
          end
        end
        chk(m ? "R10 first lo" : "R6 first lo", first_lo, p + 1);
        chk(m ? "R10 gaps lo" : "R6 gaps lo", gap_bad, 0);
        chk("R6 pulses lo", cnt_lo_p, (4 * (q + 1)) / (p + 1));
        chk("R8 first hi", first_hi, q + 1);
        chk("R8 pulses hi", cnt_hi_p, 4);
      end
    end

    // R7 one-shot sweep
    for (int p = 2; p <= 6; p++) begin
      stop_all();
      wr(8'h24, 32'h7);
      wr(8'h18, p);
      wr(8'h20, 32'h40);
      first_lo = -1; cnt_lo_p = 0;
      for (int i = 1; i <= 20; i++) begin
        @(negedge clk);
        if (irq_lo) begin
          if (first_lo < 0) first_lo = i;
          cnt_lo_p++;
        end
      end
      chk("R7 first", first_lo, p + 1);
      chk("R7 single pulse", cnt_lo_p, 1);
      rd(8'h10, d); chk("R7 count stays", d, p);
      rd(8'h20, d); chk("R7 enable cleared", d, 0);
    end

    // R9 wide counter, modes 0 and 2
    for (int m = 0; m < 2; m++) begin
      stop_all();
      wr(8'h24, m ? 32'hB : 32'h3);
      wr(8'h18, 32'h04); wr(8'h1C, 32'h01);
      wr(8'h20, 32'h00C00080);
      bus_addr = 8'h14;
      first_lo = -1; cnt_lo_p = 0; cnt_hi_p = 0; last = -1; gap_bad = 0;
      for (int i = 1; i <= 600; i++) begin
        @(negedge clk); #0.1;
        if (i == 255) chk("R9 hi before carry", bus_rdata, 0);
        if (i == 256) chk("R9 carry", bus_rdata, 1);
        if (irq_lo) begin
          if (first_lo < 0) first_lo = i;
          if (last >= 0 && i - last != 261) gap_bad++;
          last = i; cnt_lo_p++;
        end
        if (irq_hi) cnt_hi_p++;
      end
      chk("R9 first match", first_lo, 261);
      chk("R9 interval", gap_bad, 0);
      chk("R9 pulses", cnt_lo_p, 2);
      chk("R9 irq_hi quiet", cnt_hi_p, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule